// File: doc/BRIEF.md
# Card Command Line Sequencer

This block issues one command at a time on the serial command line of a memory card. Software loads a 32-bit argument and then a 32-bit command word. When the word carries its start flag, the sequencer waits until it may begin, clears that flag, and shifts out a 48-bit command frame that ends in a computed CRC7. If the command word asks for it, the sequencer first drives an idle run of clock cycles with the line high.

When a response is expected, the sequencer releases the line and waits a bounded number of cycles for the card's start bit. It then shifts in a short 48-bit reply or a long 136-bit reply, fills the response registers and, on request, checks the reply's CRC. Every outcome sets bits in a raw interrupt status register that software clears by writing ones. A command that announces a data phase gives a one-cycle handoff pulse to the data-path logic once its command phase has finished without error. The line advances one bit per `clk` cycle.

Top module: `card_cmd_issuer`

## Requirements
- R1: After reset, `int_raw`, `cmd_rdata`, all four response words and `data_start` are zero, `busy` is low and `cmd_oe` is low.
- R2: A command word with bit 31 set is accepted on the next cycle in which the sequencer is idle, unless bit 13 is set and `data_busy` is high. Acceptance clears bit 31 of `cmd_rdata` and raises `busy`. Without bit 13, a high `data_busy` does not delay acceptance.
- R3: The command frame is driven on `cmd_out` with `cmd_oe` high, MSB first, one bit per cycle. Its 48 bits are: 0, 1, index (command bits 5:0), the 32-bit argument, CRC7 (x^7+x^3+1, zero initial value, over the first 40 bits), and 1. For index 0 with argument 0, the CRC7 field is 7'h4A.
- R4: When command bit 15 is set, `cmd_out` is high with `cmd_oe` high for exactly 80 cycles before the frame's start bit.
- R5: When command bit 6 is clear, no response is awaited. Bit 2 (done) of `int_raw` is set when the frame ends, and every command ends with bit 2 set.
- R6: A short response (bit 6 set, bit 7 clear) is 48 bits. Its payload, bits 39:8 of the received frame, goes to `resp0`; `resp1` to `resp3` are left unchanged.
- R7: A long response (bits 6 and 7 set) is 136 bits. Received bits 127:0 fill `resp3:resp2:resp1:resp0`, with `resp0` holding bits 31:0.
- R8: With command bit 8 set, a CRC7 over received bits 47:8 (short) or 127:8 (long) that differs from received bits 7:1 sets `int_raw` bit 6. With bit 8 clear, bit 6 is never set.
- R9: If the line stays high for 64 sampled cycles after the frame, `int_raw` bits 8 (timeout) and 2 (done) are set together, and `busy` falls 64 cycles after `cmd_oe` falls.
- R10: `int_raw` bit 1 (response error) is set when the received end bit is 0, or when the leading header bits are wrong (2'b00 for short, 8'h3F for long).
- R11: A write on `int_clr_wr` clears exactly the `int_raw` bits that are one in `int_clr_data`. A bit being set in the same cycle stays set.
- R12: Writes to the command and argument registers are ignored while `busy` is high.
- R13: A command with bit 9 set pulses `data_start` for one cycle after it ends with no timeout, response error or CRC error. `data_write` pulses with it when bit 10 is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one command-line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command register write data |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument register write data |
| cmd_rdata | output | 32 | Current command register contents |
| int_clr_wr | input | 1 | Interrupt status clear strobe |
| int_clr_data | input | 16 | Ones clear matching status bits |
| int_raw | output | 16 | Raw interrupt status |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |
| data_busy | input | 1 | An earlier data transfer is still running |
| cmd_in | input | 1 | Command line as seen from the card |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | A command is in progress |
| data_start | output | 1 | Pulse handing a data phase to the data path |
| data_write | output | 1 | Pulse marking that data phase as a write |

## Verification
The bound checker watches, on every cycle, the relations between the ports: the start flag is clear whenever the block is busy, the command word stays frozen during a command, the line is driven only while busy, every completion and every timeout leaves the done bit set, a blocked data wait keeps the block idle, a clear from idle removes the done bit, and the data handoff happens only from idle. The frame bits and CRC values, the 80-cycle idle run, the exact 64-cycle timeout window, the placement of short and long payloads, and the selective effect of the CRC-check flag can only be shown by the bench's scenarios. These scenarios compare the line and the registers against values computed from the requirements.

// File: rtl/card_cmd_pkg.sv
package card_cmd_pkg;
  // command word flag positions (software visible)
  localparam int CB_RESP    = 6;
  localparam int CB_LONG    = 7;
  localparam int CB_CRCCHK  = 8;
  localparam int CB_DATA    = 9;
  localparam int CB_WRITE   = 10;
  localparam int CB_WAITPRV = 13;
  localparam int CB_INIT    = 15;
  localparam int CB_START   = 31;
  // raw interrupt positions
  localparam int IRQ_RESP_ERR = 1;
  localparam int IRQ_DONE     = 2;
  localparam int IRQ_RCRC     = 6;
  localparam int IRQ_RTO      = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_SEND, ST_WAIT, ST_RECV, ST_EVAL
  } seq_state_t;
endpackage

// File: rtl/card_crc7.sv
module card_crc7 #(
  parameter int W = 40
) (
  input  logic [W-1:0] din,
  output logic [6:0]   crc
);
  logic [6:0] acc;

  always_comb begin
    acc = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (din[i] ^ acc[6]) acc = {acc[5:0], 1'b0} ^ 7'h09;
      else                 acc = {acc[5:0], 1'b0};
    end
    crc = acc;
  end
endmodule

// File: rtl/card_irq_raw.sv
module card_irq_raw #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] raw
);
  logic [W-1:0] raw_q, raw_d;

  always_comb begin
    raw_d = raw_q;
    if (clr_en) raw_d = raw_d & ~clr_vec;
    raw_d = raw_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw = raw_q;
endmodule

// File: rtl/card_cmd_issuer.sv
module card_cmd_issuer
  import card_cmd_pkg::*;
#(
  parameter int IRQ_W    = 16,
  parameter int INIT_CYC = 80,
  parameter int RESP_TMO = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_wdata,
  input  logic             arg_wr,
  input  logic [31:0]      arg_wdata,
  output logic [31:0]      cmd_rdata,
  input  logic             int_clr_wr,
  input  logic [IRQ_W-1:0] int_clr_data,
  output logic [IRQ_W-1:0] int_raw,
  output logic [31:0]      resp0,
  output logic [31:0]      resp1,
  output logic [31:0]      resp2,
  output logic [31:0]      resp3,
  input  logic             data_busy,
  input  logic             cmd_in,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic             busy,
  output logic             data_start,
  output logic             data_write
);
  localparam int FRAME_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam int CRC_SPAN  = LONG_LEN - 16;
  localparam int CNT_W     = $clog2(LONG_LEN + INIT_CYC + RESP_TMO);

  seq_state_t state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [31:0]          cmd_q, cmd_d, arg_q, arg_d;
  logic [FRAME_LEN-1:0] tx_q, tx_d, tx_frame;
  logic [LONG_LEN-1:0]  rx_q, rx_d;
  logic [6:0]           tx_crc, rx_crc;
  logic [CRC_SPAN-1:0]  rx_crc_in;
  logic [IRQ_W-1:0]     set_vec;
  logic accept, is_long, hdr_bad, crc_bad, fin_ok, ld_short, ld_long;
  logic dstart_q, dwrite_q;
  logic [CNT_W-1:0] rx_last;

  assign is_long = cmd_q[CB_LONG];
  assign rx_last = is_long ? CNT_W'(LONG_LEN - 1) : CNT_W'(FRAME_LEN - 1);
  assign accept  = (state_q == ST_IDLE) && cmd_q[CB_START] &&
                   !(cmd_q[CB_WAITPRV] && data_busy);

  card_crc7 #(.W(FRAME_LEN - 8)) u_tx_crc (
    .din ({2'b01, cmd_q[5:0], arg_q}),
    .crc (tx_crc)
  );
  assign tx_frame = {2'b01, cmd_q[5:0], arg_q, tx_crc, 1'b1};

  // zero prefix leaves a zero-seeded CRC unchanged
  assign rx_crc_in = is_long ? rx_q[127:8] : {{(CRC_SPAN - 40){1'b0}}, rx_q[47:8]};
  card_crc7 #(.W(CRC_SPAN)) u_rx_crc (
    .din (rx_crc_in),
    .crc (rx_crc)
  );
  assign hdr_bad = !rx_q[0] ||
                   (is_long ? (rx_q[135:128] != 8'h3F) : (rx_q[47:46] != 2'b00));
  assign crc_bad = cmd_q[CB_CRCCHK] && (rx_crc != rx_q[7:1]);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cmd_d    = cmd_q;
    arg_d    = arg_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    set_vec  = '0;
    fin_ok   = 1'b0;
    ld_short = 1'b0;
    ld_long  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          cmd_d[CB_START] = 1'b0;
          tx_d    = tx_frame;
          cnt_d   = '0;
          state_d = cmd_q[CB_INIT] ? ST_INIT : ST_SEND;
        end else begin
          if (cmd_wr) cmd_d = cmd_wdata;
          if (arg_wr) arg_d = arg_wdata;
        end
      end
      ST_INIT: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(INIT_CYC - 1)) begin
          cnt_d   = '0;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        tx_d  = {tx_q[FRAME_LEN-2:0], 1'b1};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
          cnt_d = '0;
          if (cmd_q[CB_RESP]) state_d = ST_WAIT;
          else begin
            state_d           = ST_IDLE;
            set_vec[IRQ_DONE] = 1'b1;
            fin_ok            = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!cmd_in) begin
          rx_d    = {rx_q[LONG_LEN-2:0], cmd_in};
          cnt_d   = CNT_W'(1);
          state_d = ST_RECV;
        end else if (cnt_q == CNT_W'(RESP_TMO - 1)) begin
          state_d           = ST_IDLE;
          set_vec[IRQ_DONE] = 1'b1;
          set_vec[IRQ_RTO]  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RECV: begin
        rx_d  = {rx_q[LONG_LEN-2:0], cmd_in};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == rx_last) state_d = ST_EVAL;
      end
      ST_EVAL: begin
        state_d               = ST_IDLE;
        set_vec[IRQ_DONE]     = 1'b1;
        set_vec[IRQ_RESP_ERR] = hdr_bad;
        set_vec[IRQ_RCRC]     = crc_bad;
        fin_ok                = !hdr_bad && !crc_bad;
        ld_long               = is_long;
        ld_short              = !is_long;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      cmd_q    <= '0;
      arg_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      dstart_q <= 1'b0;
      dwrite_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      cmd_q    <= cmd_d;
      arg_q    <= arg_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      dstart_q <= fin_ok && cmd_q[CB_DATA];
      dwrite_q <= fin_ok && cmd_q[CB_DATA] && cmd_q[CB_WRITE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp0 <= '0;
      resp1 <= '0;
      resp2 <= '0;
      resp3 <= '0;
    end else if (ld_long) begin
      resp0 <= rx_q[31:0];
      resp1 <= rx_q[63:32];
      resp2 <= rx_q[95:64];
      resp3 <= rx_q[127:96];
    end else if (ld_short) begin
      resp0 <= rx_q[39:8];
    end
  end

  card_irq_raw #(.W(IRQ_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_en  (int_clr_wr),
    .clr_vec (int_clr_data),
    .raw     (int_raw)
  );

  assign cmd_rdata  = cmd_q;
  assign busy       = (state_q != ST_IDLE);
  assign cmd_oe     = (state_q == ST_INIT) || (state_q == ST_SEND);
  assign cmd_out    = (state_q == ST_SEND) ? tx_q[FRAME_LEN-1] : 1'b1;
  assign data_start = dstart_q;
  assign data_write = dwrite_q;
endmodule

// File: rtl/card_cmd_issuer_chk.sv
module card_cmd_issuer_chk #(
  parameter int IRQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      cmd_rdata,
  input logic             int_clr_wr,
  input logic [IRQ_W-1:0] int_clr_data,
  input logic [IRQ_W-1:0] int_raw,
  input logic             data_busy,
  input logic             cmd_oe,
  input logic             busy,
  input logic             data_start
);
  // R2
  start_clear_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_rdata[31]);

  // R2
  wait_prev_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_rdata[31] && cmd_rdata[13] && data_busy) |=> !busy);

  // R12
  cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_rdata));

  // R3
  drive_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);

  // R5
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> int_raw[2]);

  // R9
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_raw[8]) |-> int_raw[2]);

  // R11
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr_wr && int_clr_data[2] && !busy) |=> !int_raw[2]);

  // R13
  handoff_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |-> (!busy && int_raw[2]));
endmodule

bind card_cmd_issuer card_cmd_issuer_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_rdata    (cmd_rdata),
  .int_clr_wr   (int_clr_wr),
  .int_clr_data (int_clr_data),
  .int_raw      (int_raw),
  .data_busy    (data_busy),
  .cmd_oe       (cmd_oe),
  .busy         (busy),
  .data_start   (data_start)
);

// File: tb/sim_card_cmd_issuer.sv
`timescale 1ns/1ps
module sim_card_cmd_issuer;
  logic clk, rst_n;
  logic cmd_wr, arg_wr, int_clr_wr, data_busy, cmd_in;
  logic [31:0] cmd_wdata, arg_wdata, cmd_rdata;
  logic [15:0] int_clr_data, int_raw;
  logic [31:0] resp0, resp1, resp2, resp3;
  logic cmd_out, cmd_oe, busy, data_start, data_write;

  int errors = 0, checks = 0;
  int ds_cnt = 0, dw_cnt = 0;
  bit finished = 0;

  card_cmd_issuer u0 (.*);

  initial clk = 0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (data_start) ds_cnt++;
    if (data_write) dw_cnt++;
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] bcrc(input logic [119:0] d);
    logic [6:0] c = '0;
    for (int i = 119; i >= 0; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] a);
    return {2'b01, idx, a, bcrc({80'b0, 2'b01, idx, a}), 1'b1};
  endfunction

  function automatic logic [135:0] short_resp(input logic [5:0] idx, input logic [31:0] p);
    return {88'b0, 2'b00, idx, p, bcrc({80'b0, 2'b00, idx, p}), 1'b1};
  endfunction

  function automatic logic [135:0] long_resp(input logic [119:0] body);
    return {8'h3F, body, bcrc(body), 1'b1};
  endfunction

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic clear_all();
    @(negedge clk); int_clr_wr = 1; int_clr_data = 16'hFFFF;
    @(negedge clk); int_clr_wr = 0; int_clr_data = 0;
  endtask

  task automatic write_cmd(input logic [31:0] cw, input logic [31:0] av, input bit wa);
    @(negedge clk);
    if (wa) begin arg_wr = 1; arg_wdata = av; @(negedge clk); arg_wr = 0; end
    cmd_wr = 1; cmd_wdata = cw; @(negedge clk); cmd_wr = 0;
  endtask

  task automatic capture(output int ones, output logic [47:0] fr);
    int k = 0;
    ones = 0; fr = '0;
    while (!cmd_oe && k < 3000) begin @(negedge clk); k++; end
    while (cmd_oe && cmd_out && ones < 500) begin ones++; @(negedge clk); end
    for (int i = 0; i < 48; i++) begin fr[47-i] = cmd_out; @(negedge clk); end
  endtask

  task automatic respond(input int rlen, input logic [135:0] rb);
    repeat (5) @(negedge clk);
    for (int i = 0; i < rlen; i++) begin cmd_in = rb[rlen-1-i]; @(negedge clk); end
    cmd_in = 1;
  endtask

  task automatic run_cmd(input logic [31:0] cw, input logic [31:0] av, input bit wa,
                         input int rlen, input logic [135:0] rb,
                         output int ones, output logic [47:0] fr);
    write_cmd(cw, av, wa);
    capture(ones, fr);
    if (rlen > 0) respond(rlen, rb);
    wait_idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 int_raw", int_raw, 0);
    check("R1 cmd_rdata", cmd_rdata, 0);
    check("R1 resp", {resp3, resp2, resp1, resp0}, 0);
    check("R1 busy/oe/data_start", {busy, cmd_oe, data_start}, 0);
  endtask

  task automatic t_init_no_resp();
    int ones; logic [47:0] fr;
    clear_all();
    run_cmd(32'h8000_8000, 32'h0, 1, 0, '0, ones, fr);
    check("R4 init high cycles", ones, 80);
    check("R3 frame idx0", fr, exp_frame(6'd0, 32'h0));
    check("R3 crc7 vector", fr[7:1], 7'h4A);
    check("R5 done only", int_raw, 16'h0004);
    check("R2 start cleared", cmd_rdata[31], 0);
  endtask

  task automatic t_long();
    int ones; logic [47:0] fr;
    logic [119:0] body = 120'hA1B2C3D4_E5F60718_293A4B5C_6D7E8F;
    logic [135:0] rb = long_resp(body);
    clear_all();
    run_cmd(32'h8000_01C2, 32'h1234_5678, 1, 136, rb, ones, fr);
    check("R3 frame idx2", fr, exp_frame(6'd2, 32'h1234_5678));
    check("R7 long resp", {resp3, resp2, resp1, resp0}, rb[127:0]);
    check("R7 status", int_raw, 16'h0004);
  endtask

  task automatic t_short();
    int ones; logic [47:0] fr;
    logic [95:0] hi = {resp3, resp2, resp1};
    int ds0 = ds_cnt, dw0 = dw_cnt;
    clear_all();
    run_cmd(32'h8000_0351, 32'h0000_0200, 1, 48, short_resp(6'd17, 32'hCAFE_F00D), ones, fr);
    check("R6 resp0", resp0, 32'hCAFE_F00D);
    check("R6 resp1..3 kept", {resp3, resp2, resp1}, hi);
    check("R6 status", int_raw, 16'h0004);
    check("R13 read handoff", {ds_cnt - ds0, dw_cnt - dw0}, {32'd1, 32'd0});
  endtask

  task automatic t_crc();
    int ones; logic [47:0] fr;
    logic [135:0] rb = short_resp(6'd13, 32'h0000_0900);
    int ds0;
    rb[3] = ~rb[3];
    clear_all();
    ds0 = ds_cnt;
    run_cmd(32'h8000_034D, 32'h0, 1, 48, rb, ones, fr);
    check("R8 crc error flagged", int_raw, 16'h0044);
    check("R13 no handoff on error", ds_cnt - ds0, 0);
    clear_all();
    run_cmd(32'h8000_004D, 32'h0, 1, 48, rb, ones, fr);
    check("R8 crc not checked", int_raw, 16'h0004);
  endtask

  task automatic t_timeout();
    int ones, n = 0; logic [47:0] fr;
    int ds0 = ds_cnt;
    clear_all();
    write_cmd(32'h8000_0251, 32'h7, 1);
    capture(ones, fr);
    while (busy && n < 500) begin n++; @(negedge clk); end
    @(negedge clk);
    check("R9 wait window", n, 64);
    check("R9 timeout+done", int_raw, 16'h0104);
    check("R13 no handoff on timeout", ds_cnt - ds0, 0);
    @(negedge clk); int_clr_wr = 1; int_clr_data = 16'h0004;
    @(negedge clk); int_clr_wr = 0;
    check("R11 partial clear", int_raw, 16'h0100);
    int_clr_wr = 1; int_clr_data = 16'h0100;
    @(negedge clk); int_clr_wr = 0;
    check("R11 full clear", int_raw, 16'h0000);
  endtask

  task automatic t_end_bit();
    int ones; logic [47:0] fr;
    logic [135:0] rb = short_resp(6'd1, 32'h00FF_8000);
    rb[0] = 0;
    clear_all();
    run_cmd(32'h8000_0041, 32'h0, 1, 48, rb, ones, fr);
    check("R10 response error", int_raw, 16'h0006);
  endtask

  task automatic t_busy_write();
    int ones; logic [47:0] fr;
    clear_all();
    write_cmd(32'h8000_8005, 32'h0BAD_F00D, 1);
    repeat (4) @(negedge clk);
    cmd_wr = 1; cmd_wdata = 32'h8000_0041; arg_wr = 1; arg_wdata = 32'hDEAD_BEEF;
    @(negedge clk); cmd_wr = 0; arg_wr = 0;
    capture(ones, fr);
    wait_idle(); @(negedge clk);
    check("R12 cmd write ignored", cmd_rdata, 32'h0000_8005);
    run_cmd(32'h8000_0006, 32'h0, 0, 0, '0, ones, fr);
    check("R12 arg write ignored", fr, exp_frame(6'd6, 32'h0BAD_F00D));
  endtask

  task automatic t_wait_prev();
    int ones; logic [47:0] fr;
    clear_all();
    data_busy = 1;
    write_cmd(32'h8000_2007, 32'h1, 1);
    repeat (20) @(negedge clk);
    check("R2 held while data busy", {busy, cmd_rdata[31]}, 2'b01);
    data_busy = 0;
    capture(ones, fr);
    wait_idle(); @(negedge clk);
    check("R2 accepted after release", {cmd_rdata[31], int_raw[2]}, 2'b01);
    data_busy = 1;
    run_cmd(32'h8000_0008, 32'h2, 1, 0, '0, ones, fr);
    check("R2 no wait flag ignores data_busy", fr, exp_frame(6'd8, 32'h2));
    data_busy = 0;
  endtask

  task automatic t_write_handoff();
    int ones; logic [47:0] fr;
    int ds0 = ds_cnt, dw0 = dw_cnt;
    clear_all();
    run_cmd(32'h8000_0618, 32'h40, 1, 0, '0, ones, fr);
    check("R13 write handoff", {ds_cnt - ds0, dw_cnt - dw0}, {32'd1, 32'd1});
  endtask

  initial begin
    rst_n = 0; cmd_wr = 0; arg_wr = 0; int_clr_wr = 0; data_busy = 0; cmd_in = 1;
    cmd_wdata = 0; arg_wdata = 0; int_clr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_init_no_resp();
    t_long();
    t_short();
    t_crc();
    t_timeout();
    t_end_bit();
    t_busy_write();
    t_wait_prev();
    t_write_handoff();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule